// File: doc/BRIEF.md
# Center-Aligned PWM Timer Channel

This block is one timer channel that turns a free-running count into a pulse-width modulated output pair. A prescaler divides the clock, and a main counter runs against a programmable top value. It can count in a sawtooth, up or down, or in a triangle that climbs from zero to the top value and falls back again. A single compare value sets the duty cycle: the main output is active while the count is below the compare value. The second output is its complement, and each output has its own polarity control.

Software programs the channel through a write-only register port. The prescale ratio is always double-buffered. The top value and the compare value can each be written either straight into the working register or into a holding copy that is taken over at the next update event. An update event happens when the counter wraps or turns around, and it can also be forced by a software command. That command restarts the counter and the prescaler from zero. Two sticky flags report update events and compare matches. In the triangle modes, a two-bit alignment code chooses which slope of the triangle may raise the compare flag.

Register map (write port, address in `wr_addr`): 0 control, 1 prescale ratio, 2 top value, 3 compare value, 4 command, 5 flag clear. Control bits: bit0 run, bit1 count down (sawtooth only), bits 3:2 alignment code, bit4 compare buffering, bit5 top-value buffering, bit6 invert main output, bit7 invert complementary output.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the count, the prescaler count, both flags and all control bits are 0. The prescale ratio and the compare value are 0, the top value is all ones, and both outputs are low.
- R2: With alignment code 00 and control bit1 clear, the count steps by one from 0 up to the top value and then returns to 0. Each step occurs once every (prescale ratio + 1) clocks. The return to 0 is an update event. A count at or above the top value wraps on its next step.
- R3: With alignment code 00 and control bit1 set, the count steps down by one to 0. On its next step it reloads the top value, and that reload is an update event.
- R4: With alignment codes 01, 10 and 11, the count climbs from 0 to the top value and falls back to 0. Both turn-arounds are update events. Control bit1 has no effect in these modes. A top value of 0 holds the count at 0, and every step is then an update event.
- R5: With alignment code 01, a compare match (a step taken while the count equals the compare value) sets the compare flag only on the falling slope.
- R6: With alignment code 10, a compare match sets the compare flag only on the rising slope. At the top value the slope still counts as rising.
- R7: With alignment code 11, and in the sawtooth mode (code 00), every compare match sets the compare flag.
- R8: While running, the main output's active level holds exactly when count < compare value. A compare value above the top value therefore gives full duty, and a compare value of 0 gives none.
- R9: The complementary output is active exactly when running and the main output is not active. Control bit6 inverts the main pin and bit7 inverts the complementary pin, independently. When the channel is stopped, both outputs sit at their inactive level.
- R10: With control bit4 clear, a write to address 3 takes effect on the next clock. With bit4 set, the write only fills the holding copy, and the working compare value changes at the next update event.
- R11: A write to address 1 always waits for an update event. A write to address 2 waits for an update event when control bit5 is set and takes effect at once otherwise.
- R12: Writing address 4 with bit0 set is an update event. It zeroes the count and the prescaler count, restarts the triangle on its rising slope, copies every holding register into its working register and sets the update flag. This works whether or not the channel is running.
- R13: The update and compare flags stay set until a write to address 5 with bit0 (update) or bit1 (compare) set clears them. A new event in the same clock wins over the clear.
- R14: While control bit0 (run) is clear, the count and the prescaler count hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| count | output | CNT_W | Current counter value |
| pwm_main | output | 1 | PWM output after its polarity control |
| pwm_comp | output | 1 | Complementary PWM output after its polarity control |
| cmp_flag | output | 1 | Sticky compare-match flag |
| upd_flag | output | 1 | Sticky update-event flag |

## Verification
The assertions take the write port as the only source of change. They assume a register is never written in the same clock as an automatic update event loads it. Under that assumption, a buffered working value stays fixed between updates, and the compare flag can rise only on a real match on the permitted slope. The stimulus keeps to this by reprogramming ratios, top values and compare values only while the channel is stopped. The only writes made while it runs are the software update and the flag clears, whose collisions with live events are defined behaviour. A cycle-level expectation model, written from the requirements, supplies the expected count, pins and flags for every clock of each run window.

// File: rtl/cpwm_pkg.sv
// Shared encodings for the PWM timer channel: register addresses,
// alignment codes and the control word layout.
package cpwm_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PSC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;

    // Counting shape and which slope may raise the compare flag.
    typedef enum logic [1:0] {
        ALN_SAW      = 2'b00,
        ALN_TRI_FALL = 2'b01,
        ALN_TRI_RISE = 2'b10,
        ALN_TRI_BOTH = 2'b11
    } align_e;

    // Control word, bit0 is run (first member is the MSB).
    typedef struct packed {
        logic   inv_comp;   // bit7
        logic   inv_main;   // bit6
        logic   top_buf;    // bit5
        logic   cmp_buf;    // bit4
        align_e align;      // bits 3:2
        logic   down;       // bit1
        logic   run;        // bit0
    } ctrl_t;

endpackage

// File: rtl/cpwm_shadow.sv
// Holding/working register pair.
// Assumes: buffer_en selects whether a write goes straight to the working
// copy or waits for the next update event.
module cpwm_shadow #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             buffer_en,
    input  logic             uev,
    output logic [CNT_W-1:0] work
);

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] work_q;

    // Capture writes into the holding copy; move to working copy on demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= RST_VAL;
            work_q <= RST_VAL;
        end else begin
            if (wr_hit) hold_q <= wr_val;
            if (wr_hit && !buffer_en) work_q <= wr_val;
            else if (uev) work_q <= hold_q;
        end
    end

    assign work = work_q;

    // R10
    hold_until_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buffer_en && !uev) |=> $stable(work_q));

endmodule

// File: rtl/cpwm_regs.sv
// Register write decode for the PWM timer channel.
// Assumes: one write per clock; command and flag-clear writes are pulses
// that act in the clock of the write and store nothing.
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              uev,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  psc_work,
    output logic [CNT_W-1:0]  top_work,
    output logic [CNT_W-1:0]  cmp_work,
    output logic              sw_update,
    output logic              clr_upd,
    output logic              clr_cmp
);

    localparam logic [CNT_W-1:0] TOP_RST = '1;

    ctrl_t ctrl_q;
    logic  hit_ctrl, hit_psc, hit_top, hit_cmp, hit_cmd, hit_flag;

    // Address decode of the write strobe.
    always_comb begin
        hit_ctrl = wr_en && (wr_addr == A_CTRL);
        hit_psc  = wr_en && (wr_addr == A_PSC);
        hit_top  = wr_en && (wr_addr == A_TOP);
        hit_cmp  = wr_en && (wr_addr == A_CMP);
        hit_cmd  = wr_en && (wr_addr == A_CMD);
        hit_flag = wr_en && (wr_addr == A_FLAG);
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (hit_ctrl) ctrl_q <= ctrl_t'(wr_data[7:0]);
    end

    assign ctrl      = ctrl_q;
    assign sw_update = hit_cmd && wr_data[0];
    assign clr_upd   = hit_flag && wr_data[0];
    assign clr_cmp   = hit_flag && wr_data[1];

    cpwm_shadow #(.CNT_W(CNT_W), .RST_VAL('0)) u_psc (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_psc), .wr_val(wr_data),
        .buffer_en(1'b1), .uev(uev), .work(psc_work));

    cpwm_shadow #(.CNT_W(CNT_W), .RST_VAL(TOP_RST)) u_top (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_top), .wr_val(wr_data),
        .buffer_en(ctrl_q.top_buf), .uev(uev), .work(top_work));

    cpwm_shadow #(.CNT_W(CNT_W), .RST_VAL('0)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit_cmp), .wr_val(wr_data),
        .buffer_en(ctrl_q.cmp_buf), .uev(uev), .work(cmp_work));

    // R11
    psc_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uev |=> $stable(psc_work));

endmodule

// File: rtl/cpwm_prescaler.sv
// Clock divider: emits one tick every (ratio + 1) clocks while running.
// Assumes: ratio only changes on an update event, when the divider is at 0.
module cpwm_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] ratio,
    output logic             tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_q;

    assign tick = run && (div_q == ratio);

    // Divider count, restarted by a software update.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (clear)  div_q <= '0;
        else if (tick)   div_q <= '0;
        else if (run)    div_q <= div_q + ONE;
    end

    // R12
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (div_q == '0));

    // R14
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(div_q));

endmodule

// File: rtl/cpwm_counter.sv
// Main counter: sawtooth up/down or triangle, with wrap/turn-around events.
// Assumes: tick is a single-cycle enable from the prescaler; restart wins.
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  align_e           align,
    input  logic             down_sel,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] count,
    output logic             going_up,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             up_q, up_d;
    logic             tri_mode;

    assign tri_mode = (align != ALN_SAW);

    // Next count and event for one prescaled step.
    always_comb begin
        cnt_d = cnt_q;
        up_d  = up_q;
        wrap  = 1'b0;
        if (tick) begin
            if (!tri_mode) begin
                if (!down_sel) begin
                    if (cnt_q >= top) begin
                        cnt_d = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_d = top;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end else if (top == '0) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else if (up_q) begin
                if (cnt_q >= top) begin
                    cnt_d = top - ONE;
                    up_d  = 1'b0;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == '0) begin
                    cnt_d = ONE;
                    up_d  = 1'b1;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    // Count and slope registers.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    assign count    = cnt_q;
    assign going_up = tri_mode ? up_q : !down_sel;

    // R12
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0) && up_q);

    // R14
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));

    // R4
    tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && tri_mode && (top != '0) && (cnt_q < top)) |=>
        ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

endmodule

// File: rtl/cpwm_output.sv
// Output stage: PWM pin pair with polarity, compare and update flags.
// Assumes: count and cmp_val come from registers, so the pins are glitch-safe
// decodes of registered state.
module cpwm_output
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  align_e           align,
    input  logic             going_up,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             inv_main,
    input  logic             inv_comp,
    input  logic             uev,
    input  logic             clr_upd,
    input  logic             clr_cmp,
    output logic             pwm_main,
    output logic             pwm_comp,
    output logic             cmp_flag,
    output logic             upd_flag
);

    logic below, slope_ok, cmp_hit;
    logic cmp_q, upd_q;

    assign below    = (count < cmp_val);
    assign pwm_main = (run && below) ^ inv_main;
    assign pwm_comp = (run && !below) ^ inv_comp;

    // Which slope may raise the compare flag.
    always_comb begin
        case (align)
            ALN_SAW:      slope_ok = 1'b1;
            ALN_TRI_FALL: slope_ok = !going_up;
            ALN_TRI_RISE: slope_ok = going_up;
            ALN_TRI_BOTH: slope_ok = 1'b1;
            default:      slope_ok = 1'b1;
        endcase
    end

    assign cmp_hit = tick && (count == cmp_val) && slope_ok;

    // Sticky flags; a new event beats a clear in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            if (cmp_hit)      cmp_q <= 1'b1;
            else if (clr_cmp) cmp_q <= 1'b0;
            if (uev)          upd_q <= 1'b1;
            else if (clr_upd) upd_q <= 1'b0;
        end
    end

    assign cmp_flag = cmp_q;
    assign upd_flag = upd_q;

    // R9
    pins_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (inv_main == inv_comp)) |-> (pwm_main != pwm_comp));

    // R5
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((align == ALN_TRI_FALL) && going_up && !cmp_q) |=> !cmp_q);

    // R13
    cmp_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_q && !(tick && (count == cmp_val))) |=> !cmp_q);

    // R13
    upd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uev |=> upd_q);

endmodule

// File: rtl/cpwm_timer.sv
// PWM timer channel top: register port, prescaler, counter, output stage.
// Assumes: CNT_W >= 8 so the control word fits in the write data.
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              pwm_main,
    output logic              pwm_comp,
    output logic              cmp_flag,
    output logic              upd_flag
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] psc_work, top_work, cmp_work, cnt;
    logic             sw_update, clr_upd, clr_cmp;
    logic             tick, going_up, wrap, uev;

    assign uev   = wrap || sw_update;
    assign count = cnt;

    cpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .uev(uev), .ctrl(ctrl), .psc_work(psc_work),
        .top_work(top_work), .cmp_work(cmp_work), .sw_update(sw_update),
        .clr_upd(clr_upd), .clr_cmp(clr_cmp));

    cpwm_prescaler #(.CNT_W(CNT_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .clear(sw_update),
        .ratio(psc_work), .tick(tick));

    cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_update),
        .align(ctrl.align), .down_sel(ctrl.down), .top(top_work),
        .count(cnt), .going_up(going_up), .wrap(wrap));

    cpwm_output #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .align(ctrl.align),
        .going_up(going_up), .tick(tick), .count(cnt), .cmp_val(cmp_work),
        .inv_main(ctrl.inv_main), .inv_comp(ctrl.inv_comp), .uev(uev),
        .clr_upd(clr_upd), .clr_cmp(clr_cmp), .pwm_main(pwm_main),
        .pwm_comp(pwm_comp), .cmp_flag(cmp_flag), .upd_flag(upd_flag));

endmodule

// File: tb/tb_cpwm_timer.sv
// Scoreboard bench: the driver advances an expectation model written from the
// requirements and queues one expected item per clock; the monitor pops and
// compares a quarter period after each rising edge.
module tb_cpwm_timer;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         pwm_main, pwm_comp, cmp_flag, upd_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pwm_main(pwm_main),
        .pwm_comp(pwm_comp), .cmp_flag(cmp_flag), .upd_flag(upd_flag));

    typedef struct {
        logic [W-1:0] cnt;
        logic         pm;
        logic         pc;
        logic         cf;
        logic         uf;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    // Expectation model state
    logic         m_run, m_down, m_cbuf, m_tbuf, m_im, m_ic;
    int           m_align;
    logic [W-1:0] m_psc_h, m_psc_w, m_top_h, m_top_w, m_cmp_h, m_cmp_w;
    logic [W-1:0] m_cnt, m_div;
    logic         m_up, m_upd, m_cmp, set_u, set_c;

    task automatic m_reset();
        m_run = 0; m_down = 0; m_cbuf = 0; m_tbuf = 0; m_im = 0; m_ic = 0;
        m_align = 0;
        m_psc_h = 0; m_psc_w = 0; m_top_h = '1; m_top_w = '1;
        m_cmp_h = 0; m_cmp_w = 0;
        m_cnt = 0; m_div = 0; m_up = 1; m_upd = 0; m_cmp = 0;
    endtask

    // One clock of the requirements, taken in order
    task automatic m_step();
        logic tk, rising, ev;
        logic [W-1:0] old_top;
        set_u = 0; set_c = 0; ev = 0;
        tk = m_run && (m_div == m_psc_w);
        if (m_run) m_div = tk ? '0 : m_div + 1;
        if (tk) begin
            rising = (m_align == 0) ? !m_down : m_up;
            if (m_cnt == m_cmp_w &&
                (m_align == 0 || m_align == 3 ||
                 (m_align == 1 && !rising) || (m_align == 2 && rising)))
                set_c = 1;
            old_top = m_top_w;
            if (m_align == 0) begin
                if (!m_down) begin
                    if (m_cnt >= old_top) begin m_cnt = 0; ev = 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_cnt = old_top; ev = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end else if (old_top == 0) begin
                m_cnt = 0; ev = 1;
            end else if (m_up) begin
                if (m_cnt >= old_top) begin m_cnt = old_top - 1; m_up = 0; ev = 1; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_cnt = 1; m_up = 1; ev = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (ev) begin
                set_u = 1;
                m_psc_w = m_psc_h; m_top_w = m_top_h; m_cmp_w = m_cmp_h;
            end
        end
        if (set_c) m_cmp = 1;
        if (set_u) m_upd = 1;
    endtask

    task automatic m_write(input logic [2:0] a, input logic [W-1:0] d);
        case (a)
            3'd0: begin
                m_run = d[0]; m_down = d[1]; m_align = int'(d[3:2]);
                m_cbuf = d[4]; m_tbuf = d[5]; m_im = d[6]; m_ic = d[7];
            end
            3'd1: m_psc_h = d;
            3'd2: begin m_top_h = d; if (!m_tbuf) m_top_w = d; end
            3'd3: begin m_cmp_h = d; if (!m_cbuf) m_cmp_w = d; end
            3'd4: if (d[0]) begin
                m_cnt = 0; m_div = 0; m_up = 1;
                m_psc_w = m_psc_h; m_top_w = m_top_h; m_cmp_w = m_cmp_h;
                m_upd = 1; set_u = 1;
            end
            3'd5: begin
                if (d[0] && !set_u) m_upd = 0;
                if (d[1] && !set_c) m_cmp = 0;
            end
            default: ;
        endcase
    endtask

    // Starts and ends at a falling edge; one rising edge in between.
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        m_step();
        m_write(a, d);
        @(negedge clk);
        wr_en = 0;
    endtask

    function automatic logic [W-1:0] cw(input logic run, input logic dn,
        input int aln, input logic cb, input logic tb, input logic im, input logic ic);
        logic [W-1:0] v;
        v = '0;
        v[0] = run; v[1] = dn; v[3:2] = aln[1:0]; v[4] = cb; v[5] = tb;
        v[6] = im; v[7] = ic;
        return v;
    endfunction

    // Driver: queue n expected clocks and let them pass.
    task automatic run_for(input int n, input string tag);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            m_step();
            e.cnt = m_cnt;
            e.pm  = (m_run && (m_cnt < m_cmp_w)) ^ m_im;
            e.pc  = (m_run && !(m_cnt < m_cmp_w)) ^ m_ic;
            e.cf  = m_cmp;
            e.uf  = m_upd;
            e.tag = tag;
            exp_q.push_back(e);
        end
        repeat (n) @(negedge clk);
    endtask

    // Monitor: one comparison per queued clock.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                checks++;
                if (count !== e.cnt || pwm_main !== e.pm || pwm_comp !== e.pc ||
                    cmp_flag !== e.cf || upd_flag !== e.uf) begin
                    errors++;
                    $display("FAIL %s: got cnt=%0d main=%b comp=%b cf=%b uf=%b exp cnt=%0d main=%b comp=%b cf=%b uf=%b",
                        e.tag, count, pwm_main, pwm_comp, cmp_flag, upd_flag,
                        e.cnt, e.pm, e.pc, e.cf, e.uf);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 main", W'(pwm_main), 0);
        chk("R1 comp", W'(pwm_comp), 0);
        chk("R1 flags", W'({cmp_flag, upd_flag}), 0);

        // R2 sawtooth up, R7 compare each match, R8 duty
        wr(3'd1, 0); wr(3'd2, 4); wr(3'd3, 2);
        wr(3'd4, 1); wr(3'd5, 3);
        wr(3'd0, cw(1, 0, 0, 0, 0, 0, 0));
        run_for(12, "R2 R7 R8 saw up");

        // R14 stopped: everything holds
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        run_for(5, "R14 hold");

        // R2/R11 prescale ratio 2 taken by a software update
        wr(3'd1, 2); wr(3'd4, 1);
        wr(3'd0, cw(1, 0, 0, 0, 0, 0, 0));
        run_for(20, "R2 R11 prescale");
        // R12 software update while running restarts the divider
        wr(3'd4, 1);
        run_for(10, "R12 restart");

        // R3 sawtooth down
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd1, 0); wr(3'd4, 1); wr(3'd5, 3);
        wr(3'd0, cw(1, 1, 0, 0, 0, 0, 0));
        run_for(12, "R3 saw down");

        // R4 triangle, with R5/R6/R7 slope selection (down bit set, ignored)
        for (int a = 1; a < 4; a++) begin
            wr(3'd0, cw(0, 1, a, 0, 0, 0, 0));
            wr(3'd4, 1); wr(3'd5, 3);
            wr(3'd0, cw(1, 1, a, 0, 0, 0, 0));
            case (a)
                1: run_for(20, "R4 R5 falling-slope flag");
                2: run_for(20, "R4 R6 rising-slope flag");
                default: run_for(20, "R4 R7 both-slope flag");
            endcase
        end

        // R4 top value 0 in triangle mode
        wr(3'd0, cw(0, 0, 3, 0, 0, 0, 0));
        wr(3'd2, 0); wr(3'd4, 1); wr(3'd5, 3);
        wr(3'd0, cw(1, 0, 3, 0, 0, 0, 0));
        run_for(4, "R4 zero top");

        // R8 full duty and zero duty
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd2, 4); wr(3'd3, 5); wr(3'd4, 1);
        wr(3'd0, cw(1, 0, 0, 0, 0, 0, 0));
        run_for(8, "R8 full duty");
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd3, 0);
        wr(3'd0, cw(1, 0, 0, 0, 0, 0, 0));
        run_for(8, "R8 zero duty");

        // R9 polarity controls, running and stopped
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd3, 2);
        wr(3'd0, cw(1, 0, 0, 0, 0, 1, 0));
        run_for(6, "R9 main inverted");
        wr(3'd0, cw(1, 0, 0, 0, 0, 0, 1));
        run_for(6, "R9 comp inverted");
        wr(3'd0, cw(0, 0, 0, 0, 0, 1, 1));
        run_for(3, "R9 stopped inverted");

        // R10 buffered compare waits for the wrap; direct write is immediate
        wr(3'd0, cw(0, 0, 0, 1, 0, 0, 0));
        wr(3'd3, 4);
        wr(3'd0, cw(1, 0, 0, 1, 0, 0, 0));
        run_for(12, "R10 buffered compare");
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd3, 1);
        wr(3'd0, cw(1, 0, 0, 0, 0, 0, 0));
        run_for(6, "R10 direct compare");

        // R11 buffered top value and prescale ratio wait for the wrap
        wr(3'd0, cw(0, 0, 0, 0, 1, 0, 0));
        wr(3'd2, 2); wr(3'd1, 1);
        wr(3'd0, cw(1, 0, 0, 0, 1, 0, 0));
        run_for(24, "R11 buffered top and ratio");

        // R13 flag clears while running, one flag at a time
        wr(3'd5, 1);
        run_for(6, "R13 clear update flag");
        wr(3'd5, 2);
        run_for(6, "R13 clear compare flag");
        wr(3'd5, 3);
        run_for(6, "R13 clear both");

        // R12 software update while stopped
        wr(3'd0, cw(0, 0, 0, 0, 0, 0, 0));
        wr(3'd5, 3);
        wr(3'd4, 1);
        run_for(3, "R12 update while stopped");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule